// File: doc/BRIEF.md
# Cross-Domain Time Counter Snapshot Reader

This block keeps a free-running time counter in the fast system clock domain. A microcontroller on an unrelated, asynchronous bus can read it without ever seeing a torn value. The bus domain has no clock of its own: every flop on that side is clocked by the falling edge of the active-low read strobe. The counter itself never crosses the domain boundary. A selected read toggles a request bit. The system domain passes that bit through a two-flop synchronizer, notices the change, and in one cycle copies the counter into a holding register. It then toggles an acknowledge bit, which goes back to the bus side through two flops clocked by the strobe.

A selected read presents the holding register only when the acknowledge seen on the bus side matches the outstanding request. At that moment the copy is known to be complete and frozen. The same read also issues the next request. A read that comes while a copy is still in flight leaves the output at the last completed snapshot.

The bus data path is a plain strobe-captured register. It has no valid/ready stream, because the bus cannot stall. Back-pressure is therefore implicit: a read that comes too early gets the older coherent value.

Top module: `ctr_snapshot_reader`

## Requirements
- R1: The counter (COUNT_W bits, default 32) rises by one on each rising system clock edge and wraps from all ones to zero.
- R2: While soft_rst is high at a rising clock edge, the counter, holding register and acknowledge bit clear, overriding the increment. While soft_rst is high, the bus-side request bit, acknowledge synchronizer and rd_data are held at zero.
- R3: rd_data changes only on a falling edge of rd_n with cs_n low. A strobe with cs_n high leaves rd_data unchanged, although it still shifts the acknowledge synchronizer.
- R4: On a selected strobe, if the synchronized acknowledge equals the request bit, rd_data takes the holding register and the request bit toggles.
- R5: A request issued at a strobe falling between clock edges loads the holding register on the third following rising edge. The value loaded is the counter value that existed two edges after the strobe. The acknowledge toggles on that same edge.
- R6: The holding register changes only when a new request has arrived, so it is constant from its acknowledge until the next selected read.
- R7: On a selected strobe whose synchronized acknowledge differs from the request bit, rd_data keeps the last completed snapshot and no new request is issued.
- R8: After reset, the first selected read returns zero.
- R9: An acknowledge toggle becomes visible to the bus side on the second falling strobe edge after it happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; counter and snapshot domain |
| soft_rst | input | 1 | Synchronous soft reset of the system side, also clears the bus side |
| cs_n | input | 1 | Active-low chip select, sampled at the strobe's falling edge |
| rd_n | input | 1 | Active-low read strobe; its falling edge clocks the bus side |
| rd_data | output | COUNT_W | Last coherent snapshot returned to the bus |

## Verification
The bench runs a narrow counter so that wrap-around falls inside the run. It sweeps the gap between strobes from zero to many clock cycles, so that reads land both while a copy is pending and after it has completed. It also mixes in deselected strobes and soft resets.

Each failure mode shows up differently:
- A design that sampled the counter directly, or off by one edge, returns a value other than the exact count two edges after the request.
- A design that updated the output while the handshake was pending returns a fresh or stale value where the previous snapshot belongs.
- A design that ignored chip select changes the output on a deselected strobe.
- A design that skipped a synchronizer stage returns data one read early.

// File: rtl/snap_pkg.sv
`timescale 1ns/1ps
package snap_pkg;
  localparam int unsigned DEF_COUNT_W = 32;
  localparam int unsigned DEF_SYNC_STAGES = 2;

  typedef enum logic {
    RST_SYNC  = 1'b0,
    RST_ASYNC = 1'b1
  } rst_style_e;
endpackage

// File: rtl/snap_sync.sv
`timescale 1ns/1ps
module snap_sync
  import snap_pkg::*;
#(
  parameter int unsigned STAGES = DEF_SYNC_STAGES,
  parameter rst_style_e  RSTSTYLE = RST_SYNC
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (RSTSTYLE == RST_ASYNC) begin : g_async
      always_ff @(posedge clk or posedge rst) begin
        if (rst) chain <= '0;
        else     chain <= {chain[LAST-1:0], d};
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[LAST-1:0], d};
      end
    end
  endgenerate

  assign q = chain[LAST];
endmodule

// File: rtl/snap_sys_side.sv
`timescale 1ns/1ps
module snap_sys_side
  import snap_pkg::*;
#(
  parameter int unsigned COUNT_W = DEF_COUNT_W,
  parameter int unsigned STAGES  = DEF_SYNC_STAGES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_tgl,
  output logic [COUNT_W-1:0] count_o,
  output logic [COUNT_W-1:0] hold_o,
  output logic               ack_o
);
  localparam logic [COUNT_W-1:0] ONE = COUNT_W'(1);

  logic req_seen;
  logic req_last;
  logic take;

  snap_sync #(.STAGES(STAGES), .RSTSTYLE(RST_SYNC)) i_req_sync (
    .clk (clk),
    .rst (rst),
    .d   (req_tgl),
    .q   (req_seen)
  );

  assign take = req_seen ^ req_last;

  always_ff @(posedge clk) begin
    if (rst) count_o <= '0;
    else     count_o <= count_o + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_last <= 1'b0;
      hold_o   <= '0;
      ack_o    <= 1'b0;
    end else begin
      req_last <= req_seen;
      if (take) begin
        hold_o <= count_o;
        ack_o  <= ~ack_o;
      end
    end
  end
endmodule

// File: rtl/snap_bus_side.sv
`timescale 1ns/1ps
module snap_bus_side
  import snap_pkg::*;
#(
  parameter int unsigned COUNT_W = DEF_COUNT_W,
  parameter int unsigned STAGES  = DEF_SYNC_STAGES
) (
  input  logic               rd_n,
  input  logic               rst,
  input  logic               cs_n,
  input  logic [COUNT_W-1:0] hold_i,
  input  logic               ack_tgl,
  output logic               req_o,
  output logic               ack_seen_o,
  output logic [COUNT_W-1:0] rd_data
);
  logic strobe_clk;
  logic done;

  assign strobe_clk = ~rd_n;

  snap_sync #(.STAGES(STAGES), .RSTSTYLE(RST_ASYNC)) i_ack_sync (
    .clk (strobe_clk),
    .rst (rst),
    .d   (ack_tgl),
    .q   (ack_seen_o)
  );

  assign done = (ack_seen_o == req_o);

  always_ff @(posedge strobe_clk or posedge rst) begin
    if (rst) begin
      req_o   <= 1'b0;
      rd_data <= '0;
    end else if (!cs_n && done) begin
      rd_data <= hold_i;
      req_o   <= ~req_o;
    end
  end
endmodule

// File: rtl/ctr_snapshot_reader.sv
`timescale 1ns/1ps
module ctr_snapshot_reader
  import snap_pkg::*;
#(
  parameter int unsigned COUNT_W = DEF_COUNT_W,
  parameter int unsigned STAGES  = DEF_SYNC_STAGES
) (
  input  logic               clk,
  input  logic               soft_rst,
  input  logic               cs_n,
  input  logic               rd_n,
  output logic [COUNT_W-1:0] rd_data
);
  logic [COUNT_W-1:0] count;
  logic [COUNT_W-1:0] hold;
  logic               ack;
  logic               req;
  logic               ack_seen;

  snap_sys_side #(.COUNT_W(COUNT_W), .STAGES(STAGES)) i_sys (
    .clk     (clk),
    .rst     (soft_rst),
    .req_tgl (req),
    .count_o (count),
    .hold_o  (hold),
    .ack_o   (ack)
  );

  snap_bus_side #(.COUNT_W(COUNT_W), .STAGES(STAGES)) i_bus (
    .rd_n       (rd_n),
    .rst        (soft_rst),
    .cs_n       (cs_n),
    .hold_i     (hold),
    .ack_tgl    (ack),
    .req_o      (req),
    .ack_seen_o (ack_seen),
    .rd_data    (rd_data)
  );
endmodule

// File: rtl/snap_checker.sv
`timescale 1ns/1ps
module snap_checker #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         soft_rst,
  input logic         cs_n,
  input logic         rd_n,
  input logic [W-1:0] count,
  input logic [W-1:0] hold,
  input logic         ack,
  input logic         req,
  input logic         ack_seen,
  input logic [W-1:0] rd_data
);
  logic sys_up;
  logic bus_up;
  logic sclk;

  assign sclk = ~rd_n;

  always_ff @(posedge clk) sys_up <= 1'b1;
  always_ff @(posedge sclk or posedge soft_rst) begin
    if (soft_rst) bus_up <= 1'b0;
    else          bus_up <= 1'b1;
  end

  p_count_step_r1: assert property (@(posedge clk) disable iff (soft_rst || !sys_up)
    $past(!soft_rst) |-> count == $past(count) + W'(1));

  p_reset_clears_r2: assert property (@(posedge clk) disable iff (soft_rst || !sys_up)
    $fell(soft_rst) |-> (count == '0 && hold == '0 && !ack));

  p_hold_only_on_ack_r6: assert property (@(posedge clk) disable iff (soft_rst || !sys_up)
    $stable(ack) |-> $stable(hold));

  p_deselect_hold_r3: assert property (@(posedge sclk) disable iff (soft_rst || !bus_up)
    cs_n |=> $stable(rd_data));

  p_pending_hold_r7: assert property (@(posedge sclk) disable iff (soft_rst || !bus_up)
    (ack_seen != req) |=> ($stable(rd_data) && $stable(req)));
endmodule

bind ctr_snapshot_reader snap_checker #(.W(COUNT_W)) i_snap_checker (
  .clk      (clk),
  .soft_rst (soft_rst),
  .cs_n     (cs_n),
  .rd_n     (rd_n),
  .count    (count),
  .hold     (hold),
  .ack      (ack),
  .req      (req),
  .ack_seen (ack_seen),
  .rd_data  (rd_data)
);

// File: tb/test_ctr_snapshot_reader.sv
`timescale 1ns/1ps
module test_ctr_snapshot_reader;
  localparam int W = 8;
  localparam logic [W-1:0] MASK = '1;

  logic         clk = 1'b0;
  logic         soft_rst = 1'b1;
  logic         cs_n = 1'b1;
  logic         rd_n = 1'b1;
  logic [W-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference model state
  logic [W-1:0] m_cnt = '0;
  logic [W-1:0] m_hold = '0;
  logic         m_ack = 1'b0;
  logic         m_pend = 1'b0;
  int           m_edges = 0;
  logic         m_req = 1'b0;
  logic         m_s1 = 1'b0;
  logic         m_s2 = 1'b0;
  logic [W-1:0] m_out = '0;

  always #2.5 clk = ~clk;

  ctr_snapshot_reader #(.COUNT_W(W)) i_ctr_snapshot_reader (
    .clk      (clk),
    .soft_rst (soft_rst),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .rd_data  (rd_data)
  );

  // R1 R2 R5: counter and snapshot model
  always @(posedge clk) begin
    if (soft_rst) begin
      m_cnt = '0; m_hold = '0; m_ack = 1'b0; m_pend = 1'b0; m_edges = 0;
    end else begin
      if (m_pend) begin
        m_edges = m_edges + 1;
        if (m_edges == 3) begin
          m_hold = m_cnt;
          m_ack = ~m_ack;
          m_pend = 1'b0;
        end
      end
      m_cnt = (m_cnt + 1'b1) & MASK;
    end
  end

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: rd_data=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic strobe(input bit sel, input int gap);
    string tag;
    repeat (gap) @(posedge clk);
    @(negedge clk);
    #1;
    cs_n = !sel;
    #0.2;
    rd_n = 1'b0;
    if (!sel) tag = "R3 deselected strobe";
    else if (m_s2 == m_req) begin
      tag = "R4 R5 R6 completed read";
      m_out = m_hold;
      m_req = ~m_req;
      m_pend = 1'b1;
      m_edges = 0;
    end else tag = "R7 R9 pending read";
    m_s2 = m_s1;
    m_s1 = m_ack;
    #0.5;
    check(tag, rd_data, m_out);
    #0.3;
    rd_n = 1'b1;
    cs_n = 1'b1;
  endtask

  task automatic do_reset(input int cycles);
    @(negedge clk);
    soft_rst = 1'b1;
    m_req = 1'b0; m_s1 = 1'b0; m_s2 = 1'b0; m_out = '0;
    repeat (cycles) @(posedge clk);
    @(negedge clk);
    soft_rst = 1'b0;
    #0.5;
    check("R2 reset output", rd_data, '0);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset(3);
    // R8: first read after reset returns zero
    strobe(1'b1, 2);
    check("R8 first read zero", rd_data, '0);
    for (int gap = 0; gap < 12; gap++) begin
      for (int k = 0; k < 24; k++) begin
        strobe((k % 5) != 3, gap);
      end
    end
    do_reset(2);
    strobe(1'b1, 0);
    check("R8 first read zero after second reset", rd_data, '0);
    for (int k = 0; k < 40; k++) strobe(1'b1, (k * 7) % 9);
    // reset while a request is outstanding
    strobe(1'b1, 0);
    do_reset(4);
    for (int k = 0; k < 30; k++) strobe((k % 4) != 0, k % 6);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule